// File: doc/BRIEF.md
# UART Interrupt Source Arbiter and Identifier

This block gathers the interrupt causes of a FIFO-equipped UART and reduces them to a single interrupt request line plus an 8-bit identification byte. Software reads that byte to learn which cause is the most urgent one still pending. The causes are receive line errors, receive data at or above the FIFO trigger level, a receive idle timeout, transmit holding register empty, and a modem-line change. Each cause is held until the register access tied to it, and each can be masked through a 4-bit enable vector.

The surrounding UART feeds the block with the receive FIFO occupancy, the trigger threshold, the bit-rate tick and event pulses. It also supplies strobes for reads of the identification register, the line-status register and the receive buffer, and for writes to the transmit holding register. The FIFOs and the serial engines are not part of the block. Causes that are masked keep their pending state, so raising an enable bit later reports them.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, and whenever no enabled cause is pending, the identification byte is 0xC1 and the request line is low. Bit 0 is 1 for "nothing pending", and bits [7:6] are 11 in FIFO mode.
- R2: A `ls_event` pulse latches a line-status cause that reports low nibble 0x6. A later `rd_lsr` strobe clears it.
- R3: When `ls_event` and `rd_lsr` occur in the same cycle, the line-status cause stays pending (0xC6 with enable bit 2).
- R4: The received-data cause reports low nibble 0x4 while `rx_count` is nonzero and at least `trig_level`. Reading characters down through the trigger never raises it.
- R5: With a nonempty FIFO, 40 bit ticks (4 character times of 10 bits) with no `rx_push` and no `rd_rbr` raise the timeout cause, low nibble 0xC. A push or a buffer read clears it and restarts the count.
- R6: A `thr_empty_evt` pulse latches the holding-empty cause, low nibble 0x2. `wr_thr` clears it. `rd_iir` clears it only in a cycle where 0x2 is the reported code.
- R7: The `modem_chg` level reports low nibble 0x0 while it is high.
- R8: The fixed priority is line status, then received data, then timeout, then holding empty, then modem.
- R9: Enable bits: bit 0 gates received data and timeout, bit 1 gates holding empty, bit 2 gates line status, bit 3 gates modem. A masked cause changes neither output, but it stays pending.
- R10: `irq_o` is high exactly when some enabled cause is pending, that is, when bit 0 of the identification byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier | input | 4 | Per-cause enable bits |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| trig_level | input | CNT_W | Receive trigger threshold |
| rx_push | input | 1 | A character entered the receive FIFO |
| rd_rbr | input | 1 | Receive buffer read strobe |
| bit_tick | input | 1 | Bit-rate tick |
| ls_event | input | 1 | Overrun, parity, framing or break event |
| rd_lsr | input | 1 | Line-status register read strobe |
| thr_empty_evt | input | 1 | Transmit holding register became empty |
| wr_thr | input | 1 | Transmit holding register write strobe |
| rd_iir | input | 1 | Identification register read strobe |
| modem_chg | input | 1 | Modem-status change flag (level) |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of actions can land in the same clock. The first is a line error arriving on the very cycle software reads line status. The second is a holding-empty event coinciding with a holding-register write or an identification read. The bench drives `ls_event` and `rd_lsr` high together for one cycle and expects 0xC6 afterwards, because setting wins over clearing. It also issues `rd_iir` while a higher cause is reported and confirms that holding-empty is still reported once that cause is cleared.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   typedef logic [3:0] irq_code_t;

   // Cause indices, listed from highest to lowest priority.
   localparam int SRC_LS   = 0;
   localparam int SRC_RDA  = 1;
   localparam int SRC_TO   = 2;
   localparam int SRC_THRE = 3;
   localparam int SRC_MDM  = 4;
   localparam int NUM_SRC  = 5;

   localparam irq_code_t CODE_LS   = 4'h6;
   localparam irq_code_t CODE_RDA  = 4'h4;
   localparam irq_code_t CODE_TO   = 4'hC;
   localparam irq_code_t CODE_THRE = 4'h2;
   localparam irq_code_t CODE_MDM  = 4'h0;

   function automatic irq_code_t code_of(input int idx);
      case (idx)
         SRC_LS:   return CODE_LS;
         SRC_RDA:  return CODE_RDA;
         SRC_TO:   return CODE_TO;
         SRC_THRE: return CODE_THRE;
         default:  return CODE_MDM;
      endcase
   endfunction
endpackage

// File: rtl/uart_irq_flag.sv
// Pending flag: a set request takes precedence over a clear request.
module uart_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic pend_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_o <= 1'b0;
      else if (set_i)  pend_o <= 1'b1;
      else if (clr_i)  pend_o <= 1'b0;
   end
endmodule

// File: rtl/uart_irq_timer.sv
// Receive idle timer. It counts bit ticks while the FIFO holds data, and any
// push or read restarts it. The count saturates at the limit, which marks
// the timeout as pending.
module uart_irq_timer #(
   parameter int LIMIT = 40,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             rx_push,
   input  logic             rd_rbr,
   input  logic             bit_tick,
   output logic             hit_o
);
   localparam int TW = $clog2(LIMIT + 1);
   localparam logic [TW-1:0] LIM = TW'(LIMIT);

   if (LIMIT < 2) begin : g_lim_chk
      $error("uart_irq_timer: LIMIT must be at least 2");
   end

   logic [TW-1:0] tmr_q;
   logic          restart;

   assign restart = rx_push | rd_rbr | (rx_count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         tmr_q <= '0;
      else if (restart)                   tmr_q <= '0;
      else if (bit_tick && tmr_q != LIM)  tmr_q <= tmr_q + 1'b1;
   end

   assign hit_o = (tmr_q == LIM);
endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority selection over the enabled pending causes.
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter bit FIFO_MODE = 1'b1
) (
   input  logic [NUM_SRC-1:0] act_i,
   output logic [7:0]         id_o,
   output logic               any_o
);
   irq_code_t code;

   // Walk from lowest to highest priority so the last match wins.
   always_comb begin
      code = CODE_MDM;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (act_i[i]) code = code_of(i);
      end
   end

   assign any_o = |act_i;

   if (FIFO_MODE) begin : g_fifo
      assign id_o = {2'b11, 2'b00, any_o ? {code[3:1], 1'b0} : 4'b0001};
   end else begin : g_plain
      assign id_o = {2'b00, 2'b00, any_o ? {code[3:1], 1'b0} : 4'b0001};
   end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int FIFO_DEPTH    = 16,
   parameter int TO_CHARS      = 4,
   parameter int BITS_PER_CHAR = 10,
   parameter bit FIFO_MODE     = 1'b1,
   parameter int CNT_W         = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       ier,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] trig_level,
   input  logic             rx_push,
   input  logic             rd_rbr,
   input  logic             bit_tick,
   input  logic             ls_event,
   input  logic             rd_lsr,
   input  logic             thr_empty_evt,
   input  logic             wr_thr,
   input  logic             rd_iir,
   input  logic             modem_chg,
   output logic [7:0]       iir_o,
   output logic             irq_o
);
   localparam int TO_TICKS = TO_CHARS * BITS_PER_CHAR;

   if (CNT_W < $clog2(FIFO_DEPTH + 1)) begin : g_cw_chk
      $error("uart_irq_ident: CNT_W too narrow for FIFO_DEPTH");
   end
   if (TO_CHARS < 1 || BITS_PER_CHAR < 2) begin : g_to_chk
      $error("uart_irq_ident: timeout parameters out of range");
   end

   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] act;
   logic               thre_clr;
   logic               any;

   uart_irq_flag u_ls (
      .clk(clk), .rst_n(rst_n),
      .set_i(ls_event), .clr_i(rd_lsr),
      .pend_o(pend[SRC_LS])
   );

   assign pend[SRC_RDA] = (rx_count != '0) && (rx_count >= trig_level);

   uart_irq_timer #(.LIMIT(TO_TICKS), .CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .rx_count(rx_count), .rx_push(rx_push), .rd_rbr(rd_rbr),
      .bit_tick(bit_tick), .hit_o(pend[SRC_TO])
   );

   // Holding-empty is cleared by a write, or by a read that reports it.
   assign thre_clr = wr_thr | (rd_iir && any && iir_o[3:0] == CODE_THRE);

   uart_irq_flag u_thre (
      .clk(clk), .rst_n(rst_n),
      .set_i(thr_empty_evt), .clr_i(thre_clr),
      .pend_o(pend[SRC_THRE])
   );

   assign pend[SRC_MDM] = modem_chg;

   assign act[SRC_LS]   = pend[SRC_LS]   & ier[2];
   assign act[SRC_RDA]  = pend[SRC_RDA]  & ier[0];
   assign act[SRC_TO]   = pend[SRC_TO]   & ier[0];
   assign act[SRC_THRE] = pend[SRC_THRE] & ier[1];
   assign act[SRC_MDM]  = pend[SRC_MDM]  & ier[3];

   uart_irq_prio #(.FIFO_MODE(FIFO_MODE)) u_prio (
      .act_i(act), .id_o(iir_o), .any_o(any)
   );

   assign irq_o = any;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       ier,
   input logic [CNT_W-1:0] rx_count,
   input logic [CNT_W-1:0] trig_level,
   input logic             ls_event,
   input logic             rd_lsr,
   input logic             thr_empty_evt,
   input logic             wr_thr,
   input logic [7:0]       iir_o,
   input logic             irq_o
);
   // R10
   irq_matches_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == !iir_o[0]);

   // R2
   ls_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_event && ier[2]) |=> irq_o);

   // R3
   ls_race_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_event && rd_lsr && ier[2] && $stable(ier)) |=> (iir_o[3:0] == 4'h6));

   // R6
   thre_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_thr && !thr_empty_evt && ier == 4'b0010) |=>
      (!irq_o || $changed(ier)));

   // R8
   rda_over_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_o[3:0] == 4'h2 && !iir_o[0]) |->
      !(ier[0] && rx_count != '0 && rx_count >= trig_level));

   // R5
   timeout_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_o[3:0] == 4'hC) |-> (rx_count != '0));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ier(ier), .rx_count(rx_count),
   .trig_level(trig_level), .ls_event(ls_event), .rd_lsr(rd_lsr),
   .thr_empty_evt(thr_empty_evt), .wr_thr(wr_thr),
   .iir_o(iir_o), .irq_o(irq_o)
);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 5;
   localparam int TO_TICKS = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    ier = '0;
   logic [CW-1:0] rx_count = '0;
   logic [CW-1:0] trig_level = 5'd4;
   logic rx_push = 0, rd_rbr = 0, bit_tick = 0, ls_event = 0, rd_lsr = 0;
   logic thr_empty_evt = 0, wr_thr = 0, rd_iir = 0, modem_chg = 0;
   logic [7:0]    iir_o;
   logic          irq_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_irq_ident u_uart_irq_ident (
      .clk(clk), .rst_n(rst_n), .ier(ier), .rx_count(rx_count),
      .trig_level(trig_level), .rx_push(rx_push), .rd_rbr(rd_rbr),
      .bit_tick(bit_tick), .ls_event(ls_event), .rd_lsr(rd_lsr),
      .thr_empty_evt(thr_empty_evt), .wr_thr(wr_thr), .rd_iir(rd_iir),
      .modem_chg(modem_chg), .iir_o(iir_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [7:0] exp);
      logic exp_irq;
      exp_irq = (exp != 8'hC1);
      total++;
      if (iir_o !== exp || irq_o !== exp_irq) begin
         bad++;
         $display("FAIL %s: iir=%02h irq=%b expected iir=%02h irq=%b",
                  tag, iir_o, irq_o, exp, exp_irq);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // Strobes are raised at a falling edge and dropped at the next one.
   task automatic clear_strobes();
      rx_push = 0; rd_rbr = 0; ls_event = 0; rd_lsr = 0;
      thr_empty_evt = 0; wr_thr = 0; rd_iir = 0;
   endtask

   task automatic t_reset();
      chk("R1 reset", 8'hC1);
   endtask

   task automatic t_line();
      ier = 4'b0100;
      ls_event = 1; tick(); clear_strobes();
      chk("R2 line status set", 8'hC6);
      rd_lsr = 1; tick(); clear_strobes();
      chk("R2 line status cleared", 8'hC1);
   endtask

   task automatic t_line_race();
      ier = 4'b0100;
      ls_event = 1; rd_lsr = 1; tick(); clear_strobes();
      chk("R3 set and read same cycle", 8'hC6);
      rd_lsr = 1; tick(); clear_strobes();
      chk("R3 later read clears", 8'hC1);
   endtask

   task automatic t_rxdata();
      ier = 4'b0001; trig_level = 5'd4; bit_tick = 0;
      rx_count = 5'd3; tick();
      chk("R4 below trigger", 8'hC1);
      rx_count = 5'd4; rx_push = 1; tick(); clear_strobes();
      chk("R4 at trigger", 8'hC4);
      rx_count = 5'd16; tick();
      for (int c = 15; c >= 0; c--) begin
         rx_count = 5'(c); rd_rbr = 1; tick(); clear_strobes();
         chk($sformatf("R4 draining count=%0d", c), (c >= 4) ? 8'hC4 : 8'hC1);
      end
   endtask

   task automatic t_timeout();
      ier = 4'b0001; trig_level = 5'd4; bit_tick = 1;
      rx_count = 5'd1; rx_push = 1; tick(); clear_strobes();
      repeat (TO_TICKS - 1) tick();
      chk("R5 one tick short", 8'hC1);
      tick();
      chk("R5 timeout raised", 8'hCC);
      rx_count = 5'd2; rx_push = 1; tick(); clear_strobes();
      chk("R5 push clears", 8'hC1);
      repeat (TO_TICKS - 1) tick();
      chk("R5 push restarted count", 8'hC1);
      tick();
      chk("R5 timeout again", 8'hCC);
      rx_count = 5'd1; rd_rbr = 1; tick(); clear_strobes();
      chk("R5 read clears", 8'hC1);
      bit_tick = 0; rx_count = 5'd0; tick();
   endtask

   task automatic t_thre();
      ier = 4'b0010;
      thr_empty_evt = 1; tick(); clear_strobes();
      chk("R6 holding empty", 8'hC2);
      rd_iir = 1; tick(); clear_strobes();
      chk("R6 cleared by id read", 8'hC1);
      thr_empty_evt = 1; tick(); clear_strobes();
      wr_thr = 1; tick(); clear_strobes();
      chk("R6 cleared by write", 8'hC1);
      ier = 4'b0110;
      thr_empty_evt = 1; ls_event = 1; tick(); clear_strobes();
      chk("R6 line status on top", 8'hC6);
      rd_iir = 1; tick(); clear_strobes();
      rd_lsr = 1; tick(); clear_strobes();
      chk("R6 id read of other code keeps it", 8'hC2);
      wr_thr = 1; tick(); clear_strobes();
   endtask

   task automatic t_modem();
      ier = 4'b1000;
      modem_chg = 1; tick();
      chk("R7 modem change", 8'hC0);
      modem_chg = 0; tick();
      chk("R7 modem idle", 8'hC1);
   endtask

   task automatic t_priority();
      ier = 4'b1111; trig_level = 5'd4;
      modem_chg = 1; thr_empty_evt = 1; ls_event = 1; rx_count = 5'd4;
      tick(); clear_strobes();
      chk("R8 line status first", 8'hC6);
      rd_lsr = 1; tick(); clear_strobes();
      chk("R8 received data second", 8'hC4);
      rx_count = 5'd0; tick();
      chk("R8 holding empty next", 8'hC2);
      wr_thr = 1; tick(); clear_strobes();
      chk("R8 modem last", 8'hC0);
      modem_chg = 0; tick();
      chk("R8 all clear", 8'hC1);
   endtask

   task automatic t_mask();
      ier = 4'b0000; trig_level = 5'd4;
      ls_event = 1; thr_empty_evt = 1; modem_chg = 1; rx_count = 5'd4;
      tick(); clear_strobes();
      chk("R9 all masked", 8'hC1);
      ier = 4'b0100; tick();
      chk("R9 masked line status kept", 8'hC6);
      ier = 4'b0010; tick();
      chk("R9 masked holding empty kept", 8'hC2);
      rd_lsr = 1; wr_thr = 1; modem_chg = 0; rx_count = 5'd0; tick();
      clear_strobes(); ier = 4'b1111; tick();
      chk("R9 cleanup", 8'hC1);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1; tick();
      t_reset();
      t_line();
      t_line_race();
      t_rxdata();
      t_timeout();
      t_thre();
      t_modem();
      t_priority();
      t_mask();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule